// File: doc/BRIEF.md
# Delta-Modulation Sample Fetch Controller

This block is the memory-reader and control part of a delta-modulation audio channel. Software programs a control byte (interrupt enable, loop, rate select), a start-address register, a length register and a channel-enable bit. While bytes remain and the one-byte sample buffer is empty, the block requests the next byte on a read port. The returned byte is captured in the buffer, the current address is advanced and the remaining count is decremented.

Each fetch raises a one-cycle CPU stall pulse. When the last byte of a sample has been fetched, the sample either restarts (loop mode) or sets a sticky interrupt flag, provided the interrupt enable is set. The output unit downstream drains the buffer through a pop strobe. The rate select is not used inside the block. It is exported as a timer period taken from a fixed 16-entry table.

Top module: `dpcm_fetch_ctrl`

## Requirements
- R1: After reset, no fetch is requested, the interrupt output is low, the active output is low, the buffer is empty and the period is 428.
- R2: Bits 3:0 of the control byte select the period output from the table 428, 380, 340, 320, 286, 254, 226, 214, 190, 160, 142, 128, 106, 84, 72, 54 (index 0 first).
- R3: On a sample start, the current address loads 0xC000 + 64 × (address register), and the bytes remaining load 16 × (length register) + 1.
- R4: A fetch (rd_req high for one cycle with rd_addr equal to the current address) happens only when the buffer is empty and bytes remain. On that clock edge, rd_data is stored in the buffer, the address advances by one and the remaining count drops by one.
- R5: When the last byte is fetched with the loop bit (control bit 6) set, the sample restarts and the active output stays high.
- R6: When the last byte is fetched with loop clear and interrupt enable (control bit 7) set, the interrupt flag is set. With enable clear, it stays low.
- R7: Once set, the interrupt output stays high until a clearing write occurs.
- R8: A control write with bit 7 clear clears the interrupt flag. A control write with bit 7 set leaves it unchanged.
- R9: Writing the enable bit as 0 forces the remaining count to zero, so the active output goes low. A byte already in the buffer stays there, and no further fetch occurs.
- R10: An address increment from 0xFFFF gives 0x8000.
- R11: Writing the enable bit as 1 restarts the sample only when no bytes remain. Any enable write clears the interrupt flag.
- R12: The stall output pulses in exactly the cycles in which a fetch is requested.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| ctrl_we | input | 1 | Control byte write strobe |
| ctrl_data | input | 8 | Control byte: bit 7 interrupt enable, bit 6 loop, bits 3:0 rate |
| addr_we | input | 1 | Start-address register write strobe |
| addr_data | input | 8 | Start-address register value |
| len_we | input | 1 | Length register write strobe |
| len_data | input | 8 | Length register value |
| en_we | input | 1 | Channel-enable write strobe |
| en_data | input | 1 | Channel-enable value |
| rd_req | output | 1 | Fetch request |
| rd_addr | output | 16 | Fetch address |
| rd_data | input | 8 | Fetched byte, valid in the request cycle |
| stall | output | 1 | CPU stall pulse |
| buf_pop | input | 1 | Output unit takes the buffered byte |
| buf_full | output | 1 | Sample buffer holds a byte |
| buf_data | output | 8 | Buffered sample byte |
| irq | output | 1 | Interrupt level |
| active | output | 1 | Bytes remaining is nonzero |
| period | output | 9 | Timer period selected by the rate index |

## Verification
The bench builds the block with its default parameters: base 0xC000, address shift 6, length shift 4 and wrap target 0x8000. Under these values, an address register of 255 with a length register of 4 places a 65-byte sample at 0xFFC0, so the 0xFFFF-to-0x8000 wrap is reached within 65 fetches. A length register of 1 gives 17-byte runs. Holding the pop strobe low freezes a looping sample with a full buffer. This makes the loop reload, the enable-off drain and the mid-sample re-enable observable at exact cycles.

// File: rtl/dpcm_fetch_ctrl.sv
module dpcm_fetch_ctrl #(
  parameter int ADDR_W     = 16,
  parameter int REG_W      = 8,
  parameter int ADDR_SHIFT = 6,
  parameter int LEN_SHIFT  = 4,
  parameter int PER_W      = 9,
  parameter logic [15:0] BASE_ADDR = 16'hC000,
  parameter logic [15:0] WRAP_ADDR = 16'h8000
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              ctrl_we,
  input  logic [7:0]        ctrl_data,
  input  logic              addr_we,
  input  logic [REG_W-1:0]  addr_data,
  input  logic              len_we,
  input  logic [REG_W-1:0]  len_data,
  input  logic              en_we,
  input  logic              en_data,
  output logic              rd_req,
  output logic [ADDR_W-1:0] rd_addr,
  input  logic [7:0]        rd_data,
  output logic              stall,
  input  logic              buf_pop,
  output logic              buf_full,
  output logic [7:0]        buf_data,
  output logic              irq,
  output logic              active,
  output logic [PER_W-1:0]  period
);
  localparam int LEN_W = REG_W + LEN_SHIFT;

  logic              irq_en_q, loop_q, irq_q, full_q;
  logic [3:0]        rate_q;
  logic [REG_W-1:0]  areg_q, lreg_q;
  logic [ADDR_W-1:0] cur_q;
  logic [LEN_W-1:0]  remain_q;
  logic [7:0]        data_q;

  logic [ADDR_W-1:0] start_addr, next_addr;
  logic [LEN_W-1:0]  start_len;
  logic              fetch, last;

  assign start_addr = ADDR_W'(BASE_ADDR) + (ADDR_W'(areg_q) << ADDR_SHIFT);
  assign start_len  = (LEN_W'(lreg_q) << LEN_SHIFT) + LEN_W'(1);
  assign next_addr  = (cur_q == '1) ? ADDR_W'(WRAP_ADDR) : cur_q + ADDR_W'(1);
  assign fetch      = !full_q && (remain_q != '0);
  assign last       = fetch && (remain_q == LEN_W'(1));

  assign rd_req   = fetch;
  assign rd_addr  = cur_q;
  assign stall    = fetch;
  assign buf_full = full_q;
  assign buf_data = data_q;
  assign irq      = irq_q;
  assign active   = remain_q != '0;

  always_comb begin
    case (rate_q)
      4'd0:  period = PER_W'(428);
      4'd1:  period = PER_W'(380);
      4'd2:  period = PER_W'(340);
      4'd3:  period = PER_W'(320);
      4'd4:  period = PER_W'(286);
      4'd5:  period = PER_W'(254);
      4'd6:  period = PER_W'(226);
      4'd7:  period = PER_W'(214);
      4'd8:  period = PER_W'(190);
      4'd9:  period = PER_W'(160);
      4'd10: period = PER_W'(142);
      4'd11: period = PER_W'(128);
      4'd12: period = PER_W'(106);
      4'd13: period = PER_W'(84);
      4'd14: period = PER_W'(72);
      default: period = PER_W'(54);
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      irq_en_q <= 1'b0;
      loop_q   <= 1'b0;
      rate_q   <= '0;
      areg_q   <= '0;
      lreg_q   <= '0;
      cur_q    <= ADDR_W'(BASE_ADDR);
      remain_q <= '0;
      irq_q    <= 1'b0;
      full_q   <= 1'b0;
      data_q   <= '0;
    end else begin
      if (ctrl_we) begin
        irq_en_q <= ctrl_data[7];
        loop_q   <= ctrl_data[6];
        rate_q   <= ctrl_data[3:0];
      end
      if (addr_we) areg_q <= addr_data;
      if (len_we)  lreg_q <= len_data;

      if (fetch) begin
        data_q <= rd_data;
        full_q <= 1'b1;
        if (last && loop_q) begin
          cur_q    <= start_addr;
          remain_q <= start_len;
        end else begin
          cur_q    <= next_addr;
          remain_q <= remain_q - LEN_W'(1);
        end
        if (last && !loop_q && irq_en_q) irq_q <= 1'b1;
      end else if (buf_pop) begin
        full_q <= 1'b0;
      end

      if (ctrl_we && !ctrl_data[7]) irq_q <= 1'b0;

      if (en_we) begin
        irq_q <= 1'b0;
        if (!en_data) begin
          remain_q <= '0;
        end else if (remain_q == '0) begin
          cur_q    <= start_addr;
          remain_q <= start_len;
        end
      end
    end
  end

  assert_fill_R4: assert property (@(posedge clk) disable iff (!rst_n)
    rd_req |=> buf_full && buf_data == $past(rd_data));

  assert_loop_reload_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (last && loop_q && !en_we) |=> active);

  assert_end_irq_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (last && !loop_q && irq_en_q && !en_we && !(ctrl_we && !ctrl_data[7])) |=> irq);

  assert_irq_sticky_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (irq && !en_we && !(ctrl_we && !ctrl_data[7])) |=> irq);

  assert_irq_clear_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (ctrl_we && !ctrl_data[7]) |=> !irq);

  assert_disable_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (en_we && !en_data) |=> !active && !rd_req);

  assert_wrap_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_req && rd_addr == '1 && !last && !en_we) |=> rd_addr == ADDR_W'(WRAP_ADDR));
endmodule

// File: tb/dpcm_fetch_ctrl_tb.sv
`timescale 1ns/1ps
module dpcm_fetch_ctrl_tb;
  logic clk = 1'b0;
  always #10 clk = ~clk;

  logic rst_n, ctrl_we, addr_we, len_we, en_we, en_data, buf_pop;
  logic [7:0] ctrl_data, addr_data, len_data, rd_data, buf_data;
  logic rd_req, stall, buf_full, irq, active;
  logic [15:0] rd_addr;
  logic [8:0] period;

  dpcm_fetch_ctrl u_dut (
    .clk(clk), .rst_n(rst_n),
    .ctrl_we(ctrl_we), .ctrl_data(ctrl_data),
    .addr_we(addr_we), .addr_data(addr_data),
    .len_we(len_we), .len_data(len_data),
    .en_we(en_we), .en_data(en_data),
    .rd_req(rd_req), .rd_addr(rd_addr), .rd_data(rd_data),
    .stall(stall), .buf_pop(buf_pop), .buf_full(buf_full), .buf_data(buf_data),
    .irq(irq), .active(active), .period(period)
  );

  function automatic logic [7:0] mem(input logic [15:0] a);
    return a[7:0] ^ a[15:8] ^ 8'h5A;
  endfunction
  assign rd_data = mem(rd_addr);

  int checks = 0, errors = 0, fetch_cnt = 0, stall_cnt = 0, pushed = 0;
  bit done = 0;
  logic [15:0] exp_q[$];
  bit pend;
  logic [7:0] pend_val;
  int tbl [16] = '{428, 380, 340, 320, 286, 254, 226, 214, 190, 160, 142, 128, 106, 84, 72, 54};

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  // monitor: compares every fetch with the scoreboard queue
  always @(negedge clk) begin
    if (rst_n && !done) begin
      if (pend) begin
        chk(buf_data == pend_val, "R4 buffered byte", buf_data, pend_val);
        pend = 0;
      end
      if (rd_req) begin
        fetch_cnt++;
        if (stall) stall_cnt++;
        if (exp_q.size() == 0) chk(0, "R4 unexpected fetch", rd_addr, 0);
        else begin
          logic [15:0] e;
          e = exp_q.pop_front();
          chk(rd_addr == e, "R3/R10 fetch address", rd_addr, e);
        end
        pend = 1;
        pend_val = mem(rd_addr);
      end
    end
  end

  task automatic push(input logic [7:0] areg, input int n);
    logic [15:0] a;
    a = 16'hC000 + {areg, 6'b0};
    for (int i = 0; i < n; i++) begin
      exp_q.push_back(a);
      pushed++;
      a = (a == 16'hFFFF) ? 16'h8000 : a + 16'd1;
    end
  endtask

  task automatic wr(input int kind, input logic [7:0] d);
    @(negedge clk);
    case (kind)
      0: begin ctrl_we = 1; ctrl_data = d; end
      1: begin addr_we = 1; addr_data = d; end
      2: begin len_we = 1; len_data = d; end
      default: begin en_we = 1; en_data = d[0]; end
    endcase
    @(negedge clk);
    ctrl_we = 0; addr_we = 0; len_we = 0; en_we = 0;
  endtask

  task automatic wait_done();
    while (exp_q.size() != 0 || active) @(negedge clk);
    repeat (3) @(negedge clk);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog: actual hung expected finished");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      done = 1;
      $finish;
    end
  end

  initial begin
    int f0;
    rst_n = 0; ctrl_we = 0; addr_we = 0; len_we = 0; en_we = 0;
    ctrl_data = 0; addr_data = 0; len_data = 0; en_data = 0; buf_pop = 1;
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    chk(!rd_req && !irq && !active && !buf_full, "R1 reset outputs",
        {rd_req, irq, active, buf_full}, 0);
    chk(period == 428, "R1 reset period", period, 428);

    for (int r = 0; r < 16; r++) begin
      wr(0, 8'(r));
      chk(period == tbl[r], "R2 period table", period, tbl[r]);
    end

    // single-byte sample, interrupt enabled
    wr(1, 8'd1); wr(2, 8'd0); wr(0, 8'h80);
    push(8'd1, 1);
    wr(3, 8'd1);
    wait_done();
    chk(irq == 1, "R6 interrupt at end", irq, 1);
    repeat (5) @(negedge clk);
    chk(irq == 1, "R7 interrupt held", irq, 1);
    wr(0, 8'h8F);
    chk(irq == 1, "R8 write with enable set keeps flag", irq, 1);
    wr(0, 8'h00);
    chk(irq == 0, "R8 write with enable clear", irq, 0);

    // 17-byte sample
    wr(0, 8'h80); wr(1, 8'd3); wr(2, 8'd1);
    f0 = fetch_cnt;
    push(8'd3, 17);
    wr(3, 8'd1);
    wait_done();
    chk(fetch_cnt - f0 == 17, "R3 length 16*L+1", fetch_cnt - f0, 17);
    chk(irq == 1, "R6 interrupt after long sample", irq, 1);

    // enable write restarts when idle and clears the flag
    push(8'd3, 17);
    wr(3, 8'd1);
    chk(irq == 0, "R11 enable write clears flag", irq, 0);
    chk(active == 1, "R11 restart when idle", active, 1);
    wait_done();
    wr(0, 8'h00);
    push(8'd3, 17);
    wr(3, 8'd1);
    wr(3, 8'd1);
    wait_done();
    chk(exp_q.size() == 0 && !active, "R11 no restart while active", active, 0);
    chk(irq == 0, "R6 no interrupt when disabled", irq, 0);

    // loop with buffer held full
    @(negedge clk); buf_pop = 0;
    wr(0, 8'hC0); wr(1, 8'd2); wr(2, 8'd0);
    push(8'd2, 1);
    wr(3, 8'd1);
    repeat (4) @(negedge clk);
    chk(buf_full && exp_q.size() == 0, "R4 no fetch while full", buf_full, 1);
    chk(active == 1, "R5 loop reload", active, 1);
    chk(irq == 0, "R5 no interrupt in loop", irq, 0);
    push(8'd2, 1);
    @(negedge clk); buf_pop = 1;
    @(negedge clk); buf_pop = 0;
    repeat (3) @(negedge clk);
    chk(exp_q.size() == 0 && active, "R5 looped fetch", exp_q.size(), 0);
    wr(3, 8'd0);
    chk(active == 0, "R9 disable clears remaining", active, 1'b0);
    chk(buf_full == 1, "R9 buffer kept", buf_full, 1);
    f0 = fetch_cnt;
    @(negedge clk); buf_pop = 1;
    repeat (6) @(negedge clk);
    chk(!buf_full && fetch_cnt == f0, "R9 drains without fetch", fetch_cnt - f0, 0);

    // address wrap
    wr(0, 8'h00); wr(1, 8'hFF); wr(2, 8'd4);
    push(8'hFF, 65);
    wr(3, 8'd1);
    wait_done();
    chk(exp_q.size() == 0, "R10 wrap sample complete", exp_q.size(), 0);

    chk(stall_cnt == fetch_cnt, "R12 stall per fetch", stall_cnt, fetch_cnt);
    chk(fetch_cnt == pushed, "R12 fetch total", fetch_cnt, pushed);

    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule